// File: doc/BRIEF.md
# Game Raster Timing and Video Mixer

This block produces the complete raster timing for a monochrome paddle-and-ball arcade display. A synchronous horizontal counter steps once per pixel clock and wraps after 455 counts. A vertical counter advances once per wrapped line and wraps after 262 lines. From these two counts the block decodes the horizontal and vertical blanking windows and a composite sync. The horizontal sync pulse is placed near the middle of horizontal blanking by decoding two counter bits. This gives a front porch and a back porch close to broadcast practice.

The block also draws the centre net. It detects the rise of the counter's 256 bit through a two-stage synchroniser. That synchroniser only takes a new sample on alternate pixels, when the lowest counter bit is set. Because of this the net stripe is always exactly two pixels wide. Its width cannot shrink through any timing skew in the counter.

Raw ball, paddle and score video bits from the object logic are merged with the net. The result is a registered two-bit output level: sync, black or white. The ball is forced off in both blanking intervals, so picture content never lands in the sync periods. The net is forced off during vertical blanking.

Top module: `game_video_timing`

## Requirements
- R1: While `rstN` is low, on the following clock edge `hCount` and `vCount` go to 0 and `videoLevel` goes to black (encoding 1).
- R2: `hCount` steps by one each clock from 0 to 454 and then returns to 0. `vCount` keeps its value except on the clock where `hCount` wraps, where it steps by one from 0 to 261 and then returns to 0.
- R3: `hBlank` is high exactly while `hCount` is 0..79. `vBlank` is high exactly while `vCount` is 0..15.
- R4: Horizontal sync is active exactly when `hCount` bit 5 is set, bit 4 is clear and `hBlank` is high, which is counts 32..47. Vertical sync is active on lines 4..7. `compSync` is the exclusive OR of the two, active high.
- R5: On every line outside vertical blanking, the net makes `videoLevel` white for exactly two clocks: the clocks in which `hCount` reads 259 and 260.
- R6: On lines 0..15 the net never makes `videoLevel` white.
- R7: `ballVid` has no effect on `videoLevel` while `hBlank` or `vBlank` is high.
- R8: `videoLevel` is registered. In the clock after counts (h, v) it shows the level for those counts: 0 when `compSync` was high, 2 when the net or an object was visible, and otherwise 1.
- R9: `paddleVid` or `scoreVid` high outside both blanking intervals gives white (2) in the next clock. Inside either interval they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| ballVid | input | 1 | Raw ball video bit |
| paddleVid | input | 1 | Raw paddle video bit |
| scoreVid | input | 1 | Raw score segment video bit |
| hCount | output | 9 | Horizontal pixel count, 0..454 |
| vCount | output | 9 | Vertical line count, 0..261 |
| hBlank | output | 1 | Horizontal blanking, counts 0..79 |
| vBlank | output | 1 | Vertical blanking, lines 0..15 |
| compSync | output | 1 | Composite sync, active high |
| videoLevel | output | 2 | Registered level: 0 sync, 1 black, 2 white |

## Verification
The hardest cases to reach are the net suppression on lines 0..15 and the vertical sync lines. Both happen only once per frame of roughly 119,000 clocks. The stimulus therefore runs the raster through a full frame and on into the next, so every net position is seen on both blanked and visible lines. Throughout that run, the ball input is pulsed on every fifth pixel. This places ball pulses inside horizontal blanking, inside vertical blanking, on the sync lines and across the net stripe. Short paddle and score bursts are placed on selected lines so that they straddle the edge of horizontal blanking.

// File: rtl/vidtim_pkg.sv
package vidtim_pkg;

  typedef enum logic [1:0] {
    LVL_SYNC  = 2'd0,
    LVL_BLACK = 2'd1,
    LVL_WHITE = 2'd2
  } levelT;

  // Strobes and decoded windows passed from control to datapath
  typedef struct packed {
    logic tick1H;   // lowest counter bit set: net synchroniser samples
    logic bitNet;   // counter bit whose rise marks the screen centre
    logic hBlank;
    logic vBlank;
    logic hSync;
    logic vSync;
  } strobeT;

endpackage

// File: rtl/vidtim_ctrl.sv
module vidtim_ctrl
  import vidtim_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int H_TOTAL      = 455,
  parameter int V_TOTAL      = 262,
  parameter int H_BLANK_END  = 80,
  parameter int V_BLANK_END  = 16,
  parameter int V_SYNC_FIRST = 4,
  parameter int V_SYNC_LAST  = 7,
  parameter int HS_SET_BIT   = 5,
  parameter int HS_CLR_BIT   = 4,
  parameter int NET_BIT      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output strobeT           strobes
);

  localparam logic [CNT_W-1:0] H_LAST   = CNT_W'(H_TOTAL - 1);
  localparam logic [CNT_W-1:0] V_LAST   = CNT_W'(V_TOTAL - 1);
  localparam logic [CNT_W-1:0] H_BL_END = CNT_W'(H_BLANK_END);
  localparam logic [CNT_W-1:0] V_BL_END = CNT_W'(V_BLANK_END);
  localparam logic [CNT_W-1:0] VS_FIRST = CNT_W'(V_SYNC_FIRST);
  localparam logic [CNT_W-1:0] VS_LAST  = CNT_W'(V_SYNC_LAST);

  logic lineEnd;
  logic frameEnd;

  assign lineEnd  = (hCount == H_LAST);
  assign frameEnd = (vCount == V_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
    end else if (lineEnd) begin
      hCount <= '0;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCount <= '0;
    end else if (lineEnd) begin
      if (frameEnd) begin
        vCount <= '0;
      end else begin
        vCount <= vCount + 1'b1;
      end
    end
  end

  logic hBlankDec;
  logic vBlankDec;

  assign hBlankDec = (hCount < H_BL_END);
  assign vBlankDec = (vCount < V_BL_END);

  always_comb begin
    strobes.tick1H = hCount[0];
    strobes.bitNet = hCount[NET_BIT];
    strobes.hBlank = hBlankDec;
    strobes.vBlank = vBlankDec;
    strobes.hSync  = hBlankDec & hCount[HS_SET_BIT] & ~hCount[HS_CLR_BIT];
    strobes.vSync  = (vCount >= VS_FIRST) && (vCount <= VS_LAST);
  end

endmodule

// File: rtl/vidtim_datapath.sv
module vidtim_datapath
  import vidtim_pkg::*;
#(
  parameter int NET_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobes,
  input  logic   ballVid,
  input  logic   paddleVid,
  input  logic   scoreVid,
  output logic   compSync,
  output levelT  videoLevel
);

  // Net synchroniser: shift register advancing only on 1H strobes
  logic [NET_STAGES-1:0] netShift;

  generate
    for (genvar s = 0; s < NET_STAGES; s++) begin : g_netStage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            netShift[s] <= 1'b0;
          end else if (strobes.tick1H) begin
            netShift[s] <= strobes.bitNet;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) begin
            netShift[s] <= 1'b0;
          end else if (strobes.tick1H) begin
            netShift[s] <= netShift[s-1];
          end
        end
      end
    end
  endgenerate

  logic netPulse;
  logic netGated;
  logic ballGated;
  logic anyBlank;
  logic objVisible;
  levelT nextLevel;

  assign netPulse   = netShift[NET_STAGES-2] & ~netShift[NET_STAGES-1];
  assign anyBlank   = strobes.hBlank | strobes.vBlank;
  assign netGated   = netPulse & ~strobes.vBlank;
  assign ballGated  = ballVid & ~anyBlank;
  assign objVisible = ballGated | ((paddleVid | scoreVid) & ~anyBlank);
  assign compSync   = strobes.hSync ^ strobes.vSync;

  always_comb begin
    if (compSync) begin
      nextLevel = LVL_SYNC;
    end else if (netGated | objVisible) begin
      nextLevel = LVL_WHITE;
    end else begin
      nextLevel = LVL_BLACK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      videoLevel <= LVL_BLACK;
    end else begin
      videoLevel <= nextLevel;
    end
  end

endmodule

// File: rtl/game_video_timing.sv
module game_video_timing
  import vidtim_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int H_TOTAL      = 455,
  parameter int V_TOTAL      = 262,
  parameter int H_BLANK_END  = 80,
  parameter int V_BLANK_END  = 16,
  parameter int V_SYNC_FIRST = 4,
  parameter int V_SYNC_LAST  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ballVid,
  input  logic             paddleVid,
  input  logic             scoreVid,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             hBlank,
  output logic             vBlank,
  output logic             compSync,
  output logic [1:0]       videoLevel
);

  strobeT strobes;
  levelT  levelOut;

  vidtim_ctrl #(
    .CNT_W       (CNT_W),
    .H_TOTAL     (H_TOTAL),
    .V_TOTAL     (V_TOTAL),
    .H_BLANK_END (H_BLANK_END),
    .V_BLANK_END (V_BLANK_END),
    .V_SYNC_FIRST(V_SYNC_FIRST),
    .V_SYNC_LAST (V_SYNC_LAST),
    .HS_SET_BIT  (5),
    .HS_CLR_BIT  (4),
    .NET_BIT     (8)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hCount (hCount),
    .vCount (vCount),
    .strobes(strobes)
  );

  vidtim_datapath #(
    .NET_STAGES(2)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ballVid   (ballVid),
    .paddleVid (paddleVid),
    .scoreVid  (scoreVid),
    .compSync  (compSync),
    .videoLevel(levelOut)
  );

  assign hBlank     = strobes.hBlank;
  assign vBlank     = strobes.vBlank;
  assign videoLevel = levelOut;

endmodule

// File: rtl/game_video_timing_chk.sv
module game_video_timing_chk (
  input logic       clk,
  input logic       rstN,
  input logic [8:0] hCount,
  input logic [8:0] vCount,
  input logic       hBlank,
  input logic       vBlank,
  input logic       compSync,
  input logic [1:0] videoLevel
);

  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCount == 9'd454) |=> (hCount == 9'd0));

  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCount != 9'd454) |=> $stable(vCount));

  // R3
  hblank_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hBlank) |-> (hCount == 9'd80));

  // R4
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    compSync |-> (hBlank || vBlank));

  // R7
  white_not_after_hblank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (videoLevel == 2'd2) |-> !$past(hBlank));

  // R8
  sync_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (videoLevel == 2'd0) |-> $past(compSync));

  // R8
  level_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    videoLevel != 2'd3);

endmodule

bind game_video_timing game_video_timing_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hCount    (hCount),
  .vCount    (vCount),
  .hBlank    (hBlank),
  .vBlank    (vBlank),
  .compSync  (compSync),
  .videoLevel(videoLevel)
);

// File: tb/test_game_video_timing.sv
`timescale 1ns/1ps
module test_game_video_timing;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ballVid = 1'b0;
  logic       paddleVid = 1'b0;
  logic       scoreVid = 1'b0;
  logic [8:0] hCount;
  logic [8:0] vCount;
  logic       hBlank;
  logic       vBlank;
  logic       compSync;
  logic [1:0] videoLevel;

  always #2 clk = ~clk;

  game_video_timing i_game_video_timing (
    .clk       (clk),
    .rstN      (rstN),
    .ballVid   (ballVid),
    .paddleVid (paddleVid),
    .scoreVid  (scoreVid),
    .hCount    (hCount),
    .vCount    (vCount),
    .hBlank    (hBlank),
    .vBlank    (vBlank),
    .compSync  (compSync),
    .videoLevel(videoLevel)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int expQ[$];
  string tagQ[$];
  int hExp = 0;
  int vExp = 0;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", tag, hExp, vExp, actual, expected);
    end
  endtask

  // Driver: choose inputs for the current counts and push the expected level
  task automatic drive_and_push();
    bit hs, vs, blank, net, ball, pad, scr;
    int lvl;
    string tag;
    ball = (hExp % 5) == 0;
    pad  = (vExp == 100 || vExp == 10) && hExp >= 70 && hExp <= 90;
    scr  = (vExp == 50) && hExp >= 300 && hExp <= 303;
    ballVid = ball; paddleVid = pad; scoreVid = scr;
    hs = hExp >= 32 && hExp <= 47;
    vs = vExp >= 4 && vExp <= 7;
    blank = hExp < 80 || vExp < 16;
    net = (hExp == 258 || hExp == 259) && vExp >= 16;
    if (hs ^ vs) begin
      lvl = 0; tag = "R8_sync";
    end else if (net) begin
      lvl = 2; tag = "R5_net";
    end else if (!blank && (pad || scr)) begin
      lvl = 2; tag = "R9_object";
    end else if (!blank && ball) begin
      lvl = 2; tag = "R8_ball";
    end else begin
      lvl = 1;
      if ((hExp == 258 || hExp == 259) && vExp < 16) tag = "R6_net_vblank";
      else if (blank && ball) tag = "R7_ball_blank";
      else if (blank && (pad || scr)) tag = "R9_blank";
      else tag = "R8_black";
    end
    expQ.push_back(lvl);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare ports against the bench model away from the edge
  task automatic monitor_check();
    int lvl;
    string tag;
    check("R2_h", int'(hCount), hExp);
    check("R2_v", int'(vCount), vExp);
    check("R3_hblank", int'(hBlank), int'(hExp < 80));
    check("R3_vblank", int'(vBlank), int'(vExp < 16));
    check("R4_csync", int'(compSync),
          int'((hExp >= 32 && hExp <= 47) ^ (vExp >= 4 && vExp <= 7)));
    if (expQ.size() > 0) begin
      lvl = expQ.pop_front();
      tag = tagQ.pop_front();
      check(tag, int'(videoLevel), lvl);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1_h", int'(hCount), 0);
    check("R1_v", int'(vCount), 0);
    check("R1_level", int'(videoLevel), 1);
    rstN = 1'b1;
    hExp = 0; vExp = 0;
    for (int c = 0; c < 125000; c++) begin
      drive_and_push();
      @(posedge clk);
      if (hExp == 454) begin
        hExp = 0;
        vExp = (vExp == 261) ? 0 : vExp + 1;
      end else begin
        hExp++;
      end
      @(negedge clk);
      monitor_check();
    end
    // R1: reset mid-frame returns to origin
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1_h_again", int'(hCount), 0);
    check("R1_v_again", int'(vCount), 0);
    check("R1_level_again", int'(videoLevel), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule